// File: doc/BRIEF.md
# Three-Pass Karatsuba GF(2^128) Multiplier

This block multiplies two 128-bit elements of the binary field used for GCM authentication and returns the reduced 128-bit product. The field is defined by G = X^128 + X^7 + X^2 + X + 1. A request is one cycle of `start_i` while the unit is idle. The operands and the bit-order mode are captured in that cycle. The block then works through three passes. Each pass routes one pair of 64-bit halves through a single shared 64x64 carry-less multiplier.

The passes follow the Karatsuba split. The first pass multiplies the low halves. The second multiplies the high halves. The third multiplies the XOR of the two halves of each operand. Each partial product is scaled by its pass-specific power of X and reduced modulo G straight away. The reduced value is XORed into a 128-bit accumulator, so the block never holds a full 256-bit product. After the third pass the accumulator holds the answer. It is registered on `prod_o` and marked by a one-cycle `done_o` pulse.

With `reflect_i` set, the block follows the bit order that GCM uses for its block values. The operands are bit-reversed on entry and the result is bit-reversed on exit, around the same polynomial core.

Top module: `gcm3_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `prod_o` is all zeros.
- R2: `start_i` is accepted only while `busy_o` is 0. A start raised while busy is ignored: the operation in progress keeps its operands and result, and no extra `done_o` pulse follows.
- R3: If a start is accepted at clock edge k, `done_o` is 1 in exactly the cycle that follows edge k + 3*PASS_CYC, where PASS_CYC = 1 + CLMUL_REG. `done_o` stays high for one cycle. `busy_o` is 1 from edge k until that same edge.
- R4: With `reflect_i` = 0, bit i of each operand and of `prod_o` is the coefficient of X^i, and `prod_o` equals opa * opb mod G.
- R5: With `reflect_i` = 1, bit i of each operand and of `prod_o` is the coefficient of X^(127-i), and `prod_o` is the field product in that ordering.
- R6: The reduction uses G = X^128 + X^7 + X^2 + X + 1. For example, X^127 times X yields 128'h87 in the plain ordering.
- R7: A zero operand gives a zero product. The field element 1 gives the other operand unchanged: bit 0 in plain mode, bit 127 in reflected mode. All-ones operands give the field product.
- R8: `prod_o` keeps its value in every cycle in which `done_o` is 0.
- R9: The three passes run in the fixed order low halves, high halves, then folded halves. Each pass lasts PASS_CYC cycles. The result is published only at the end of the third pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a multiplication (taken only when idle) |
| reflect_i | input | 1 | 1 selects reversed (GCM) bit order for this request |
| opa_i | input | 128 | First operand |
| opb_i | input | 128 | Second operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: `prod_o` has been updated |
| prod_o | output | 128 | Reduced product of the last completed operation |

## Verification
The bench builds the block with CLMUL_REG = 1, so that the multiplier output is registered and every pass lasts two cycles. In that build the pass sub-cycle counter is exercised. A pass that advanced too early or too late would shift the done pulse away from the six-cycle latency. The latency check, and the checker's own latency counter, would then report it. Every result is compared against a bit-serial shift-and-reduce model in the bench. The comparison covers both bit orders, zero, one, all-ones, the X^127·X wrap, random operands, and a start raised while the unit is busy.

// File: rtl/gcm3_pkg.sv
package gcm3_pkg;

  localparam int HALF_W = 64;
  localparam int BLK_W  = 2 * HALF_W;
  localparam int WIDE_W = 2 * BLK_W;

  typedef enum logic [1:0] {
    PASS_LL  = 2'd0,
    PASS_HH  = 2'd1,
    PASS_MID = 2'd2
  } pass_t;

  // carry-less product of two half-width polynomials
  function automatic logic [BLK_W-1:0] clmul_half(
    input logic [HALF_W-1:0] a,
    input logic [HALF_W-1:0] b
  );
    logic [BLK_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (a[i]) acc ^= ({{HALF_W{1'b0}}, b} << i);
    end
    return acc;
  endfunction

  // place a partial product at the powers of X its pass calls for
  function automatic logic [WIDE_W-1:0] place_pass(
    input logic [BLK_W-1:0] p,
    input pass_t            which
  );
    logic [WIDE_W-1:0] base;
    logic [WIDE_W-1:0] res;
    base = {{BLK_W{1'b0}}, p};
    case (which)
      PASS_LL:  res = base ^ (base << HALF_W);
      PASS_HH:  res = (base << HALF_W) ^ (base << BLK_W);
      PASS_MID: res = base << HALF_W;
      default:  res = '0;
    endcase
    return res;
  endfunction

  // reduce a double-width polynomial modulo X^128 + X^7 + X^2 + X + 1
  function automatic logic [BLK_W-1:0] fold_mod_g(
    input logic [WIDE_W-1:0] m
  );
    logic [BLK_W-1:0] upper;
    logic [BLK_W-1:0] spill;
    logic [BLK_W-1:0] adj;
    upper = m[WIDE_W-1:BLK_W];
    // terms of upper*g that cross degree 128, folded once more
    spill = (upper >> (BLK_W - 7)) ^ (upper >> (BLK_W - 2)) ^ (upper >> (BLK_W - 1));
    adj   = upper ^ spill;
    return m[BLK_W-1:0] ^ adj ^ (adj << 1) ^ (adj << 2) ^ (adj << 7);
  endfunction

endpackage

// File: rtl/gcm3_clmul.sv
module gcm3_clmul
  import gcm3_pkg::*;
#(
  parameter int OUT_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] mul_a,
  input  logic [HALF_W-1:0] mul_b,
  output logic [BLK_W-1:0]  mul_p
);

  logic [BLK_W-1:0] raw_p;

  assign raw_p = clmul_half(mul_a, mul_b);

  generate
    if (OUT_REG != 0) begin : g_reg
      logic [BLK_W-1:0] p_q;
      always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= raw_p;
      end
      assign mul_p = p_q;
    end else begin : g_comb
      assign mul_p = raw_p;
    end
  endgenerate

endmodule

// File: rtl/gcm3_fold.sv
module gcm3_fold
  import gcm3_pkg::*;
(
  input  logic [BLK_W-1:0] part_p,
  input  pass_t            which,
  input  logic [BLK_W-1:0] acc_in,
  output logic [BLK_W-1:0] acc_out
);

  logic [WIDE_W-1:0] placed;
  logic [BLK_W-1:0]  reduced;

  always_comb begin
    placed  = place_pass(part_p, which);
    reduced = fold_mod_g(placed);
    acc_out = acc_in ^ reduced;
  end

endmodule

// File: rtl/gcm3_rev.sv
module gcm3_rev #(
  parameter int W = 128
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] flipped;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign flipped[i] = din[W-1-i];
    end
  endgenerate

  assign dout = en ? flipped : din;

endmodule

// File: rtl/gcm3_ctrl.sv
module gcm3_ctrl
  import gcm3_pkg::*;
#(
  parameter int PASS_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  output logic  accept,
  output logic  busy,
  output pass_t pass_idx,
  output logic  pass_end,
  output logic  last_end
);

  localparam int SUB_W = (PASS_CYC > 1) ? $clog2(PASS_CYC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PASS_CYC - 1);

  logic [SUB_W-1:0] sub_q;
  logic             busy_q;
  pass_t            pass_q;

  assign accept   = start_i && !busy_q;
  assign pass_end = busy_q && (sub_q == SUB_LAST);
  assign last_end = pass_end && (pass_q == PASS_MID);
  assign busy     = busy_q;
  assign pass_idx = pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pass_q <= PASS_LL;
      sub_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      pass_q <= PASS_LL;
      sub_q  <= '0;
    end else if (busy_q) begin
      if (pass_end) begin
        sub_q <= '0;
        if (pass_q == PASS_MID) busy_q <= 1'b0;
        else                    pass_q <= pass_t'(pass_q + 2'd1);
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gcm3_mult.sv
module gcm3_mult
  import gcm3_pkg::*;
#(
  parameter int CLMUL_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              reflect_i,
  input  logic [BLK_W-1:0]  opa_i,
  input  logic [BLK_W-1:0]  opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BLK_W-1:0]  prod_o
);

  localparam int PASS_CYC = 1 + ((CLMUL_REG != 0) ? 1 : 0);

  // control events, named for the checker
  logic  accept;
  logic  pass_end;
  logic  last_end;
  pass_t pass_idx;

  logic [BLK_W-1:0]  a_in, b_in;
  logic [BLK_W-1:0]  opa_q, opb_q;
  logic [HALF_W-1:0] xa_q, xb_q;
  logic              mode_q;
  logic [HALF_W-1:0] mul_a, mul_b;
  logic [BLK_W-1:0]  mul_p;
  logic [BLK_W-1:0]  acc_q, acc_nx;
  logic [BLK_W-1:0]  res_out;
  logic [BLK_W-1:0]  prod_q;
  logic              done_q;

  gcm3_ctrl #(.PASS_CYC(PASS_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept   (accept),
    .busy     (busy_o),
    .pass_idx (pass_idx),
    .pass_end (pass_end),
    .last_end (last_end)
  );

  gcm3_rev #(.W(BLK_W)) u_rev_a (.en(reflect_i), .din(opa_i), .dout(a_in));
  gcm3_rev #(.W(BLK_W)) u_rev_b (.en(reflect_i), .din(opb_i), .dout(b_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      opa_q  <= a_in;
      opb_q  <= b_in;
      mode_q <= reflect_i;
    end
  end

  // folded halves for the third pass, formed while the first pass runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xa_q <= '0;
      xb_q <= '0;
    end else if (busy_o && pass_idx == PASS_LL) begin
      xa_q <= opa_q[BLK_W-1:HALF_W] ^ opa_q[HALF_W-1:0];
      xb_q <= opb_q[BLK_W-1:HALF_W] ^ opb_q[HALF_W-1:0];
    end
  end

  always_comb begin
    case (pass_idx)
      PASS_HH: begin
        mul_a = opa_q[BLK_W-1:HALF_W];
        mul_b = opb_q[BLK_W-1:HALF_W];
      end
      PASS_MID: begin
        mul_a = xa_q;
        mul_b = xb_q;
      end
      default: begin
        mul_a = opa_q[HALF_W-1:0];
        mul_b = opb_q[HALF_W-1:0];
      end
    endcase
  end

  gcm3_clmul #(.OUT_REG(CLMUL_REG)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .mul_a (mul_a),
    .mul_b (mul_b),
    .mul_p (mul_p)
  );

  gcm3_fold u_fold (
    .part_p  (mul_p),
    .which   (pass_idx),
    .acc_in  (acc_q),
    .acc_out (acc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (accept)   acc_q <= '0;
    else if (pass_end) acc_q <= acc_nx;
  end

  gcm3_rev #(.W(BLK_W)) u_rev_o (.en(mode_q), .din(acc_nx), .dout(res_out));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_end;
      if (last_end) prod_q <= res_out;
    end
  end

  assign done_o = done_q;
  assign prod_o = prod_q;

endmodule

// File: rtl/gcm3_mult_chk.sv
module gcm3_mult_chk #(
  parameter int PASS_CYC = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [127:0] prod_o,
  input logic [127:0] opa_q,
  input logic         accept,
  input logic         pass_end,
  input logic [1:0]   pass_idx
);

  localparam logic [7:0] LAT_DONE = 8'(3 * PASS_CYC + 1);

  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (accept)         lat_cnt <= 8'd1;
    else if (done_o)         lat_cnt <= '0;
    else if (lat_cnt != '0)  lat_cnt <= lat_cnt + 8'd1;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> !accept); // R2
  AST_OPND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i) |=> $stable(opa_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> lat_cnt == LAT_DONE); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $fell(busy_o)); // R3
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(prod_o)); // R8
  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> pass_idx != 2'd3); // R9
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pass_end && pass_idx != 2'd2) |=> pass_idx == $past(pass_idx) + 2'd1); // R9
  AST_LAST_PASS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (pass_end && pass_idx == 2'd2) |=> done_o); // R9

endmodule

bind gcm3_mult gcm3_mult_chk #(.PASS_CYC(PASS_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .prod_o   (prod_o),
  .opa_q    (opa_q),
  .accept   (accept),
  .pass_end (pass_end),
  .pass_idx (pass_idx)
);

// File: tb/gcm3_mult_test.sv
module gcm3_mult_test;

  localparam int CLMUL_REG = 1;
  localparam int PASS_CYC  = 1 + CLMUL_REG;
  localparam int LATENCY   = 3 * PASS_CYC;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         reflect_i = 1'b0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic         busy_o, done_o;
  logic [127:0] prod_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  gcm3_mult #(.CLMUL_REG(CLMUL_REG)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reflect_i(reflect_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  // bit-serial reference: walk a's bits, doubling b modulo G each step
  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0;
    logic [127:0] v = b;
    for (int i = 0; i < 128; i++) begin
      logic top;
      if (a[i]) z ^= v;
      top = v[127];
      v = v << 1;
      if (top) v ^= 128'h87;
    end
    return z;
  endfunction

  function automatic logic [127:0] flip(input logic [127:0] x);
    logic [127:0] y;
    for (int i = 0; i < 128; i++) y[i] = x[127-i];
    return y;
  endfunction

  function automatic logic [127:0] ref_any(input logic [127:0] a, input logic [127:0] b, input logic r);
    return r ? flip(ref_mul(flip(a), flip(b))) : ref_mul(a, b);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        finish_run();
      end
    end
  end

  // drive one request and wait for its edge of acceptance
  task automatic launch(input logic [127:0] a, input logic [127:0] b, input logic r);
    @(negedge clk);
    opa_i = a; opb_i = b; reflect_i = r; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // count edges from acceptance until done is seen; called at first negedge after acceptance
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b, input logic r);
    int lat;
    launch(a, b, r);
    wait_done(lat);
    check(req, prod_o, ref_any(a, b, r));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", {127'b0, busy_o}, '0);
    check("R1 done in reset", {127'b0, done_o}, '0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 prod after reset", prod_o, '0);
    check("R1 busy after reset", {127'b0, busy_o}, '0);
  endtask

  task automatic t_latency();
    int lat;
    logic [127:0] a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    logic [127:0] b = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;
    launch(a, b, 1'b0);
    check("R3 busy after accept", {127'b0, busy_o}, 128'd1);
    wait_done(lat);
    check("R3 R9 latency", 128'(lat), 128'(LATENCY));
    check("R3 busy low at done", {127'b0, busy_o}, '0);
    check("R4 R9 product", prod_o, ref_mul(a, b));
    @(posedge clk);
    @(negedge clk);
    check("R3 done one cycle", {127'b0, done_o}, '0);
  endtask

  task automatic t_plain();
    run_op("R4 R9 halves pattern", 128'hffff_ffff_ffff_ffff_0000_0000_0000_0000,
           128'h0000_0000_0000_0000_ffff_ffff_ffff_ffff, 1'b0);
    run_op("R4 sparse", 128'h8000_0000_0000_0001_0000_0000_0000_0100,
           128'h0000_0000_0004_0000_8000_0000_0000_0003, 1'b0);
    for (int k = 0; k < 6; k++) run_op("R4 random", rnd128(), rnd128(), 1'b0);
  endtask

  task automatic t_edges();
    logic [127:0] x = rnd128();
    run_op("R6 wrap X^127*X", 128'h1 << 127, 128'h2, 1'b0);
    check("R6 wrap value", prod_o, 128'h87);
    run_op("R7 zero a", '0, x, 1'b0);
    check("R7 zero result", prod_o, '0);
    run_op("R7 one plain", 128'h1, x, 1'b0);
    check("R7 one plain value", prod_o, x);
    run_op("R7 one reflected", 128'h1 << 127, x, 1'b1);
    check("R7 one reflected value", prod_o, x);
    run_op("R7 all ones", '1, '1, 1'b0);
    run_op("R7 all ones reflected", '1, '1, 1'b1);
  endtask

  task automatic t_reflect();
    run_op("R5 fixed", 128'h66e9_4bd4_ef8a_2c3b_884c_fa59_ca34_2b2e,
           128'h0388_dace_60b6_a392_f328_c2b9_71b2_fe78, 1'b1);
    for (int k = 0; k < 4; k++) run_op("R5 random", rnd128(), rnd128(), 1'b1);
  endtask

  task automatic t_busy_start();
    int lat;
    int extra = 0;
    logic [127:0] a1 = rnd128();
    logic [127:0] b1 = rnd128();
    launch(a1, b1, 1'b0);
    opa_i = rnd128(); opb_i = rnd128(); reflect_i = 1'b1; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    wait_done(lat);
    check("R2 latency kept", 128'(lat + 1), 128'(LATENCY));
    check("R2 first result kept", prod_o, ref_mul(a1, b1));
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) extra++;
    end
    check("R2 no extra done", 128'(extra), '0);
    check("R8 prod held", prod_o, ref_mul(a1, b1));
  endtask

  task automatic t_hold();
    logic [127:0] held;
    run_op("R4 before hold", rnd128(), rnd128(), 1'b0);
    held = prod_o;
    launch(rnd128(), rnd128(), 1'b0);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R8 prod held while busy", prod_o, held);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_plain();
    t_edges();
    t_reflect();
    t_busy_start();
    t_hold();
    finish_run();
  end

endmodule